// File: doc/BRIEF.md
# Power-Good Monitor and Interrupt Aggregator

This block watches six supply rails through pairs of digital comparator results. One comparator per rail reports that the rail sits above its low threshold. The other reports that it sits below its high threshold. The comparator levels are first brought into the clock domain and filtered with a programmable hold time. From the filtered levels the block works out whether each rail is valid, under one global checking mode. It shows the live validity of every rail in a status register.

Each enabled rail raises a sticky flag when it turns valid and another when it turns invalid. Each of those two kinds of flag has its own per-rail mask. The flags are cleared by writing ones to them. An active-low interrupt line stays low while any flag is held.

Two power-good outputs each combine a programmable set of rails. The second output can be switched over to act as a plain level driven from a control bit.

Software reaches the block through a plain single-cycle register port. A write is taken on the clock edge where `reg_wr_en` is high. Read data follows `reg_addr` combinationally. The port has no back-pressure, because every access completes in the cycle it is presented.

Rail bit positions are the same in every rail-wide register: bit 0 and bit 1 are the two step-down outputs, bit 2 is the boost output, bit 3 is the input supply, and bits 4 and 5 are the two external monitor inputs.

Top module: `power_good_monitor`

## Requirements
- R1: Rail i is valid when `cmp_uv_ok[i]` is 1, if CTRL (address 0x0) bit 0 is 0. If that bit is 1, rail i is valid only when both `cmp_uv_ok[i]` and `cmp_ov_ok[i]` are 1. STATUS (address 0x7) bit i reads the filtered validity of rail i, with 1 meaning valid, whatever the enables, masks and flags hold.
- R2: Let D be the value in FILTER (address 0x1). A comparator level is accepted only after it has been sampled for D+1 consecutive clocks. Any shorter pulse changes nothing in status, flags or outputs. A level change that is held is visible in STATUS within D+4 clocks.
- R3: A rail enabled in ENABLE (address 0x2) that turns from invalid to valid sets bit i of RISE_FLAGS (address 0x8). It does not do so when bit i of RISE_MASK (address 0x3) is 1.
- R4: An enabled rail that turns from valid to invalid sets bit i of FALL_FLAGS (address 0x9), unless bit i of FALL_MASK (address 0x4) is 1. In window mode this holds whichever threshold is crossed.
- R5: A rail whose ENABLE bit is 0 sets no flag and has no effect on either power-good output.
- R6: Writing 1 to a bit of RISE_FLAGS or FALL_FLAGS clears that bit, and writing 0 leaves it unchanged. If an event for the same bit lands in the clearing cycle, the bit stays set.
- R7: `irq_n` is 0 while any bit of RISE_FLAGS or FALL_FLAGS is 1, and returns to 1 only when all of them are 0. Setting masks after a flag has been raised does not release the line.
- R8: `pg0` is 1 exactly when every rail that is both enabled and selected in PG0_SEL (address 0x5) is valid. With no such rail it is 1.
- R9: When CTRL bit 1 is 0, `pg1` follows the R8 rule using PG1_SEL (address 0x6). When CTRL bit 1 is 1, `pg1` drives the value of CTRL bit 2.
- R10: After reset all registers read 0, `pg0` and `pg1` are 1, and `irq_n` is 1.
- R11: CTRL (bits 2:0), FILTER (bits 7:0) and the rail registers (bits 5:0) read back what was written. A write to STATUS has no effect, and unused addresses read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr_en | input | 1 | Write strobe, taken at the clock edge |
| reg_addr | input | 4 | Register address |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data for `reg_addr` |
| cmp_uv_ok | input | 6 | Per rail: 1 when the rail is above its low threshold |
| cmp_ov_ok | input | 6 | Per rail: 1 when the rail is below its high threshold |
| pg0 | output | 1 | First power-good output |
| pg1 | output | 1 | Second power-good output or general-purpose level |
| irq_n | output | 1 | Active-low interrupt |

## Verification
The case that matters most is a write-one-to-clear of a flag that falls on the same clock edge as a new event for that same flag.

The bench first makes the flag already set. It then moves the rail through invalid and back to valid. It counts the sync and filter registers so that the clearing write lands exactly on the edge where the rising event is registered. The flag must then read 1 and `irq_n` must stay low, where a clear-wins design would show 0.

A plain clear with no event pending is checked next to it. Randomised rail patterns and configurations are judged against a bench model of validity, flags and power-good values after each settle.

// File: rtl/pgm_pkg.sv
package pgm_pkg;
  localparam int RAILS_DEF  = 6;
  localparam int DATA_W_DEF = 8;
  localparam int ADDR_W_DEF = 4;

  // register addresses
  localparam int ADR_CTRL   = 0;
  localparam int ADR_FILTER = 1;
  localparam int ADR_ENABLE = 2;
  localparam int ADR_RMASK  = 3;
  localparam int ADR_FMASK  = 4;
  localparam int ADR_SEL0   = 5;
  localparam int ADR_SEL1   = 6;
  localparam int ADR_STATUS = 7;
  localparam int ADR_RFLAG  = 8;
  localparam int ADR_FFLAG  = 9;

  typedef struct packed {
    logic gpo_level;   // bit 2
    logic pg1_as_gpo;  // bit 1
    logic window;      // bit 0
  } ctrl_t;

  localparam int CTRL_W = $bits(ctrl_t);
endpackage

// File: rtl/pgm_filter.sv
module pgm_filter #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             din,
  input  logic [CNT_W-1:0] hold_len,
  output logic             dout
);
  logic             s1_q, s2_q;
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_q  <= 1'b0;
      s2_q  <= 1'b0;
      cnt_q <= '0;
      dout  <= 1'b0;
    end else begin
      s1_q <= din;
      s2_q <= s1_q;
      if (s2_q == dout) begin
        cnt_q <= '0;
      end else if (cnt_q >= hold_len) begin
        dout  <= s2_q;
        cnt_q <= '0;
      end else begin
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end

  // R2
  filter_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(dout) |-> (dout == $past(s2_q)));
endmodule

// File: rtl/pgm_rail_edge.sv
module pgm_rail_edge #(
  parameter int N = 6
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         window,
  input  logic [N-1:0] uv_f,
  input  logic [N-1:0] ov_f,
  input  logic [N-1:0] enable,
  output logic [N-1:0] valid,
  output logic [N-1:0] rise_evt,
  output logic [N-1:0] fall_evt
);
  logic [N-1:0] prev_q;

  always_comb begin
    valid = window ? (uv_f & ov_f) : uv_f;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= '0;
    else        prev_q <= valid;
  end

  assign rise_evt = valid & ~prev_q & enable;
  assign fall_evt = ~valid & prev_q & enable;

  // R1
  status_mode_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !window |-> (valid == uv_f));
endmodule

// File: rtl/pgm_flag_bank.sv
module pgm_flag_bank #(
  parameter int N = 6
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] evt,
  input  logic [N-1:0] mask,
  input  logic [N-1:0] clr,
  output logic [N-1:0] flag
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) flag <= '0;
    else        flag <= (flag & ~clr) | (evt & ~mask);
  end

  for (genvar i = 0; i < N; i++) begin : g_chk
    // R3
    masked_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!flag[i] && mask[i]) |=> !flag[i]);
    // R6
    event_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (evt[i] && !mask[i]) |=> flag[i]);
  end
endmodule

// File: rtl/pgm_pg_combine.sv
module pgm_pg_combine #(
  parameter int N = 6
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] valid,
  input  logic [N-1:0] enable,
  input  logic [N-1:0] sel0,
  input  logic [N-1:0] sel1,
  input  logic         pg1_as_gpo,
  input  logic         gpo_level,
  output logic         pg0,
  output logic         pg1
);
  logic [N-1:0] use0, use1;
  logic         good0, good1;

  always_comb begin
    use0  = sel0 & enable;
    use1  = sel1 & enable;
    good0 = &(valid | ~use0);
    good1 = &(valid | ~use1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pg0 <= 1'b1;
      pg1 <= 1'b1;
    end else begin
      pg0 <= good0;
      pg1 <= pg1_as_gpo ? gpo_level : good1;
    end
  end

  // R8
  pg0_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((sel0 & enable) == '0) |=> pg0);
  // R8
  pg0_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !pg0 |-> $past(|(sel0 & enable & ~valid)));
endmodule

// File: rtl/power_good_monitor.sv
module power_good_monitor
  import pgm_pkg::*;
#(
  parameter int NUM_RAILS = RAILS_DEF,
  parameter int DATA_W    = DATA_W_DEF,
  parameter int ADDR_W    = ADDR_W_DEF
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 reg_wr_en,
  input  logic [ADDR_W-1:0]    reg_addr,
  input  logic [DATA_W-1:0]    reg_wdata,
  output logic [DATA_W-1:0]    reg_rdata,
  input  logic [NUM_RAILS-1:0] cmp_uv_ok,
  input  logic [NUM_RAILS-1:0] cmp_ov_ok,
  output logic                 pg0,
  output logic                 pg1,
  output logic                 irq_n
);
  localparam int N = NUM_RAILS;

  ctrl_t              ctrl_q;
  logic [DATA_W-1:0]  hold_q;
  logic [N-1:0]       en_q, rmask_q, fmask_q, sel0_q, sel1_q;
  logic [N-1:0]       uv_f, ov_f, valid, rise_evt, fall_evt;
  logic [N-1:0]       rise_flag, fall_flag, rise_clr, fall_clr;

  function automatic logic hit(input logic [ADDR_W-1:0] a, input int code);
    return a == ADDR_W'(code);
  endfunction

  // configuration registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q  <= '0;
      hold_q  <= '0;
      en_q    <= '0;
      rmask_q <= '0;
      fmask_q <= '0;
      sel0_q  <= '0;
      sel1_q  <= '0;
    end else if (reg_wr_en) begin
      if (hit(reg_addr, ADR_CTRL))   ctrl_q  <= ctrl_t'(reg_wdata[CTRL_W-1:0]);
      if (hit(reg_addr, ADR_FILTER)) hold_q  <= reg_wdata;
      if (hit(reg_addr, ADR_ENABLE)) en_q    <= reg_wdata[N-1:0];
      if (hit(reg_addr, ADR_RMASK))  rmask_q <= reg_wdata[N-1:0];
      if (hit(reg_addr, ADR_FMASK))  fmask_q <= reg_wdata[N-1:0];
      if (hit(reg_addr, ADR_SEL0))   sel0_q  <= reg_wdata[N-1:0];
      if (hit(reg_addr, ADR_SEL1))   sel1_q  <= reg_wdata[N-1:0];
    end
  end

  assign rise_clr = (reg_wr_en && hit(reg_addr, ADR_RFLAG)) ? reg_wdata[N-1:0] : '0;
  assign fall_clr = (reg_wr_en && hit(reg_addr, ADR_FFLAG)) ? reg_wdata[N-1:0] : '0;

  // per-rail input conditioning
  for (genvar i = 0; i < N; i++) begin : g_rail
    pgm_filter #(.CNT_W(DATA_W)) u_uv (
      .clk      (clk),
      .rst_n    (rst_n),
      .din      (cmp_uv_ok[i]),
      .hold_len (hold_q),
      .dout     (uv_f[i])
    );
    pgm_filter #(.CNT_W(DATA_W)) u_ov (
      .clk      (clk),
      .rst_n    (rst_n),
      .din      (cmp_ov_ok[i]),
      .hold_len (hold_q),
      .dout     (ov_f[i])
    );
  end

  pgm_rail_edge #(.N(N)) u_edge (
    .clk      (clk),
    .rst_n    (rst_n),
    .window   (ctrl_q.window),
    .uv_f     (uv_f),
    .ov_f     (ov_f),
    .enable   (en_q),
    .valid    (valid),
    .rise_evt (rise_evt),
    .fall_evt (fall_evt)
  );

  pgm_flag_bank #(.N(N)) u_rise (
    .clk   (clk),
    .rst_n (rst_n),
    .evt   (rise_evt),
    .mask  (rmask_q),
    .clr   (rise_clr),
    .flag  (rise_flag)
  );

  pgm_flag_bank #(.N(N)) u_fall (
    .clk   (clk),
    .rst_n (rst_n),
    .evt   (fall_evt),
    .mask  (fmask_q),
    .clr   (fall_clr),
    .flag  (fall_flag)
  );

  pgm_pg_combine #(.N(N)) u_pg (
    .clk        (clk),
    .rst_n      (rst_n),
    .valid      (valid),
    .enable     (en_q),
    .sel0       (sel0_q),
    .sel1       (sel1_q),
    .pg1_as_gpo (ctrl_q.pg1_as_gpo),
    .gpo_level  (ctrl_q.gpo_level),
    .pg0        (pg0),
    .pg1        (pg1)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) irq_n <= 1'b1;
    else        irq_n <= ~|(rise_flag | fall_flag);
  end

  // read mux
  always_comb begin
    reg_rdata = '0;
    if (hit(reg_addr, ADR_CTRL))   reg_rdata[CTRL_W-1:0] = ctrl_q;
    if (hit(reg_addr, ADR_FILTER)) reg_rdata = hold_q;
    if (hit(reg_addr, ADR_ENABLE)) reg_rdata[N-1:0] = en_q;
    if (hit(reg_addr, ADR_RMASK))  reg_rdata[N-1:0] = rmask_q;
    if (hit(reg_addr, ADR_FMASK))  reg_rdata[N-1:0] = fmask_q;
    if (hit(reg_addr, ADR_SEL0))   reg_rdata[N-1:0] = sel0_q;
    if (hit(reg_addr, ADR_SEL1))   reg_rdata[N-1:0] = sel1_q;
    if (hit(reg_addr, ADR_STATUS)) reg_rdata[N-1:0] = valid;
    if (hit(reg_addr, ADR_RFLAG))  reg_rdata[N-1:0] = rise_flag;
    if (hit(reg_addr, ADR_FFLAG))  reg_rdata[N-1:0] = fall_flag;
  end

  // R7
  irq_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|(rise_flag | fall_flag)) |=> !irq_n);
  // R5
  disabled_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((rise_flag == '0) && (fall_flag == '0) && (en_q == '0)) |=> !(|(rise_flag | fall_flag)));
endmodule

// File: tb/sim_power_good_monitor.sv
module sim_power_good_monitor;
  localparam int N = 6;
  localparam logic [3:0] A_CTRL = 4'h0, A_DG = 4'h1, A_EN = 4'h2, A_RM = 4'h3, A_FM = 4'h4;
  localparam logic [3:0] A_S0 = 4'h5, A_S1 = 4'h6, A_ST = 4'h7, A_RF = 4'h8, A_FF = 4'h9;

  logic clk = 1'b0, rst_n = 1'b0;
  logic reg_wr_en = 1'b0;
  logic [3:0] reg_addr = '0;
  logic [7:0] reg_wdata = '0;
  logic [7:0] reg_rdata;
  logic [N-1:0] cmp_uv_ok = '0, cmp_ov_ok = '0;
  logic pg0, pg1, irq_n;

  int n_chk = 0, n_fail = 0;
  bit done = 0;

  // bench model
  logic win = 0, gpo = 0, lvl = 0;
  logic [7:0] dg = 0;
  logic [N-1:0] en = 0, rm = 0, fm = 0, s0 = 0, s1 = 0, er = 0, ef = 0;

  always #10 clk = ~clk;

  power_good_monitor u0 (
    .clk(clk), .rst_n(rst_n), .reg_wr_en(reg_wr_en), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .cmp_uv_ok(cmp_uv_ok),
    .cmp_ov_ok(cmp_ov_ok), .pg0(pg0), .pg1(pg1), .irq_n(irq_n)
  );

  function automatic logic [N-1:0] valid_of(input logic [N-1:0] u, o, input logic w);
    return w ? (u & o) : u;
  endfunction

  function automatic logic pg_of(input logic [N-1:0] v, e, s);
    return &(v | ~(s & e));
  endfunction

  task automatic chk(input string req, input string what, input logic [31:0] act, exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [7:0] d);
    @(negedge clk);
    reg_wr_en = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr_en = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [7:0] d);
    @(negedge clk);
    reg_addr = a;
    #1 d = reg_rdata;
  endtask

  task automatic settle();
    repeat (int'(dg) + 8) @(negedge clk);
  endtask

  task automatic note(input logic [N-1:0] a, b);
    er |= b & ~a & en & ~rm;
    ef |= ~b & a & en & ~fm;
  endtask

  task automatic set_cfg(input logic w, g, l, input logic [7:0] d,
                         input logic [N-1:0] e, r, f, p0, p1);
    logic [N-1:0] va;
    va = valid_of(cmp_uv_ok, cmp_ov_ok, win);
    wr(A_DG, d); dg = d;
    wr(A_EN, {2'b0, e}); en = e;
    wr(A_RM, {2'b0, r}); rm = r;
    wr(A_FM, {2'b0, f}); fm = f;
    wr(A_S0, {2'b0, p0}); s0 = p0;
    wr(A_S1, {2'b0, p1}); s1 = p1;
    wr(A_CTRL, {5'b0, l, g, w}); win = w; gpo = g; lvl = l;
    note(va, valid_of(cmp_uv_ok, cmp_ov_ok, win));
    settle();
  endtask

  task automatic drive(input logic [N-1:0] u, o);
    logic [N-1:0] va;
    va = valid_of(cmp_uv_ok, cmp_ov_ok, win);
    @(negedge clk);
    cmp_uv_ok = u; cmp_ov_ok = o;
    note(va, valid_of(u, o, win));
    settle();
  endtask

  task automatic clr(input logic [N-1:0] r, f);
    wr(A_RF, {2'b0, r}); er &= ~r;
    wr(A_FF, {2'b0, f}); ef &= ~f;
  endtask

  task automatic check_state(input string ctx);
    logic [7:0] d;
    logic [N-1:0] v;
    v = valid_of(cmp_uv_ok, cmp_ov_ok, win);
    rd(A_ST, d); chk("R1", {ctx, " status"}, d, {2'b0, v});
    rd(A_RF, d); chk("R3", {ctx, " rise flags"}, d, {2'b0, er});
    rd(A_FF, d); chk("R4", {ctx, " fall flags"}, d, {2'b0, ef});
    chk("R8", {ctx, " pg0"}, pg0, pg_of(v, en, s0));
    chk("R9", {ctx, " pg1"}, pg1, gpo ? lvl : pg_of(v, en, s1));
    chk("R7", {ctx, " irq_n"}, irq_n, (er | ef) == '0);
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL R10 watchdog: actual timeout expected completion");
      finish_run();
    end
  end

  initial begin
    logic [7:0] d;
    void'($urandom(32'd715));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R10 reset state
    chk("R10", "pg0 after reset", pg0, 1);
    chk("R10", "pg1 after reset", pg1, 1);
    chk("R10", "irq_n after reset", irq_n, 1);
    for (int a = 0; a < 10; a++) begin
      rd(4'(a), d);
      chk("R10", $sformatf("reg %0d after reset", a), d, 0);
    end

    // R11 readback and ignored writes
    wr(A_EN, 8'h2A); rd(A_EN, d); chk("R11", "enable readback", d, 8'h2A);
    wr(A_DG, 8'hC5); rd(A_DG, d); chk("R11", "filter readback", d, 8'hC5);
    wr(A_ST, 8'hFF); rd(A_ST, d); chk("R11", "status write ignored", d, 0);
    rd(4'hC, d); chk("R11", "unused address", d, 0);

    // baseline: all rails enabled, all invalid
    set_cfg(0, 0, 0, 0, 6'h3F, 0, 0, 6'h3F, 6'h30);
    check_state("baseline");

    // R3 all rails turn valid
    drive(6'h3F, 6'h3F);
    check_state("R3 all valid");

    // R4 window mode, both thresholds
    set_cfg(1, 0, 0, 0, 6'h3F, 0, 0, 6'h3F, 6'h30);
    drive(6'h3F, 6'h3D);
    check_state("R4 upper crossing");
    drive(6'h3B, 6'h3D);
    check_state("R4 lower crossing");
    clr(6'h3F, 6'h3F);
    check_state("R6 clear all");
    drive(6'h3F, 6'h3F);
    clr(6'h3F, 6'h3F);

    // R5 disabled rail 4 dropping
    set_cfg(0, 0, 0, 0, 6'h2F, 0, 0, 6'h3F, 6'h3F);
    drive(6'h2F, 6'h3F);
    chk("R5", "pg0 with disabled rail low", pg0, 1);
    chk("R5", "pg1 with disabled rail low", pg1, 1);
    rd(A_FF, d); chk("R5", "no fall flag for disabled rail", d, 0);
    check_state("R5");
    drive(6'h3F, 6'h3F);
    rd(A_RF, d); chk("R5", "no rise flag for disabled rail", d, 0);

    // R2 filter: D=3, 3-cycle pulse rejected, 4-cycle accepted
    set_cfg(0, 0, 0, 3, 6'h3F, 0, 0, 6'h3F, 0);
    @(negedge clk); cmp_uv_ok[0] = 1'b0;
    repeat (3) @(negedge clk); cmp_uv_ok[0] = 1'b1;
    settle();
    rd(A_ST, d); chk("R2", "short pulse status", d, 8'h3F);
    rd(A_FF, d); chk("R2", "short pulse no flag", d, 0);
    @(negedge clk); cmp_uv_ok[0] = 1'b0;
    repeat (4) @(negedge clk); cmp_uv_ok[0] = 1'b1;
    settle();
    er[0] = 1'b1; ef[0] = 1'b1;
    rd(A_FF, d); chk("R2", "held pulse fall flag", d, 8'h01);
    rd(A_RF, d); chk("R2", "held pulse rise flag", d, 8'h01);
    clr(6'h3F, 6'h3F);

    // R6 collision: clear and new rising event on the same edge
    set_cfg(0, 0, 0, 0, 6'h3F, 0, 0, 6'h3F, 0);
    drive(6'h3E, 6'h3F);
    drive(6'h3F, 6'h3F);
    drive(6'h3E, 6'h3F);
    rd(A_RF, d); chk("R6", "rise flag before collision", d, 8'h01);
    @(negedge clk); cmp_uv_ok[0] = 1'b1;
    repeat (3) @(negedge clk);
    reg_wr_en = 1'b1; reg_addr = A_RF; reg_wdata = 8'h01;
    @(negedge clk); reg_wr_en = 1'b0;
    settle();
    rd(A_RF, d); chk("R6", "event wins over clear", d, 8'h01);
    chk("R6", "irq held after collision", irq_n, 0);
    wr(A_RF, 8'h00); rd(A_RF, d); chk("R6", "zero write keeps flag", d, 8'h01);
    wr(A_RF, 8'h01); er[0] = 1'b0;
    rd(A_RF, d); chk("R6", "one write clears", d, 0);
    clr(6'h3F, 6'h3F);

    // R7 masks set after flag do not release irq
    drive(6'h37, 6'h3F);
    set_cfg(0, 0, 0, 0, 6'h3F, 6'h3F, 6'h3F, 6'h3F, 0);
    chk("R7", "irq after late mask", irq_n, 0);
    clr(6'h3F, 6'h3F);
    settle();
    chk("R7", "irq released after clear", irq_n, 1);
    drive(6'h3F, 6'h3F);
    chk("R3", "masked rise sets nothing", irq_n, 1);

    // R9 general-purpose mode and R8 empty selection
    set_cfg(0, 1, 1, 0, 6'h3F, 0, 0, 0, 6'h3F);
    drive(6'h00, 6'h3F);
    chk("R9", "pg1 as gpo high", pg1, 1);
    chk("R8", "pg0 empty selection", pg0, 1);
    set_cfg(0, 1, 0, 0, 6'h3F, 0, 0, 0, 6'h3F);
    chk("R9", "pg1 as gpo low", pg1, 0);
    check_state("R9");
    clr(6'h3F, 6'h3F);

    // randomised patterns
    for (int it = 0; it < 60; it++) begin
      if ($urandom % 3 == 0)
        set_cfg(1'($urandom), 1'($urandom), 1'($urandom), 8'($urandom % 4),
                6'($urandom | $urandom), 6'($urandom & $urandom), 6'($urandom & $urandom),
                6'($urandom), 6'($urandom));
      drive(6'($urandom | $urandom), 6'($urandom | $urandom));
      check_state($sformatf("random %0d", it));
      if ($urandom % 2 == 0) begin
        clr(6'($urandom), 6'($urandom));
        settle();
        check_state($sformatf("random clear %0d", it));
      end
    end

    done = 1;
    finish_run();
  end
endmodule